// File: doc/BRIEF.md
# Escaped Packet Framer with Idle Fill

This block turns a stream of packet bytes, each tagged with a last-byte flag, into one physical byte stream for a serial shifter. Every packet opens with a start marker, a channel marker and the channel number byte. A payload byte that equals a reserved code goes out as a two-byte pair: an escape prefix, then the byte with bit 5 inverted. The end marker is placed just before the final payload byte, not after it.

The shifter pulls bytes. On any cycle with `out_take` high it samples `out_byte`, and the framer moves on to the next slot. If no packet byte is available on a slot, the framer fills it with the idle code. The shifter can therefore pull on every slot without a valid signal of its own.

The source side uses a valid/ready handshake. A byte is consumed only on the slot that carries its final encoded form. While an escape prefix or a marker is going out, `in_ready` stays low, so the source keeps holding the byte and the framer stores no copy of it.

Top module: `esc_framer`

## Requirements
- R1: After reset, with `in_valid` low, `out_byte` is the idle code 0x4A and `in_ready` is low.
- R2: Each packet opens with the three bytes 0x7A (start), 0x7C (channel marker), 0x00 (channel number). The first payload byte follows them.
- R3: A payload byte equal to 0x7A, 0x7B, 0x7C or 0x7D is sent as 0x7D followed by the byte XOR 0x20.
- R4: A payload byte equal to 0x4A or 0x4D is sent as 0x4D followed by the byte XOR 0x20.
- R5: The end marker 0x7B is sent immediately before the encoded form of the byte flagged last. If that byte is reserved, its escape pair follows the end marker.
- R6: On every slot where `in_valid` is low, `out_byte` is 0x4A. This holds between packets and in gaps inside a packet. A packet byte never encodes to 0x4A.
- R7: `in_ready` is high only when `out_take` is high and the slot carries the final encoded byte of the presented input. It stays low during markers and escape prefixes.
- R8: A packet with one payload byte is sent as 0x7A, 0x7C, 0x00, 0x7B, then the encoded byte.
- R9: While `out_take` is low the framer does not advance. With inputs held, `out_byte` is unchanged and `in_ready` is low.
- R10: A payload byte that is not reserved is sent once, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Source presents a packet byte |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Byte is the last of its packet |
| in_ready | output | 1 | Presented byte is consumed this cycle |
| out_take | input | 1 | Shifter pulls the current output byte |
| out_byte | output | 8 | Byte offered to the shifter |

## Verification
The checker watches several properties on every cycle:
- a consumed byte is never a reserved code and always matches the input, raw or folded;
- an escape prefix appears only when the held input is of the matching class;
- the end marker appears only while the last byte is held;
- empty slots carry idle;
- a stalled shifter freezes the output.

Some properties cover whole sequences and need the bench's scenarios. These are the three-byte header order, the exact position of the end marker, the one-byte packet form and the full byte-for-byte stream. The bench sweeps every byte value through first, middle and last positions. It varies the gaps on the source side and the stall pattern on the shifter side.

// File: rtl/esc_framer_pkg.sv
// Shared constants and types for the escaped packet framer.
// Assumes 8-bit physical bytes; all reserved codes live here.
package esc_framer_pkg;

    localparam int BYTE_W   = 8;
    localparam int N_PKT_CD = 4;
    localparam int N_PHY_CD = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t MK_SOP    = 8'h7A;
    localparam byte_t MK_EOP    = 8'h7B;
    localparam byte_t MK_CHAN   = 8'h7C;
    localparam byte_t MK_PESC   = 8'h7D;
    localparam byte_t MK_IDLE   = 8'h4A;
    localparam byte_t MK_XESC   = 8'h4D;
    localparam byte_t FOLD_MASK = 8'h20;

    localparam byte_t PKT_CODES [N_PKT_CD] = '{MK_SOP, MK_EOP, MK_CHAN, MK_PESC};
    localparam byte_t PHY_CODES [N_PHY_CD] = '{MK_IDLE, MK_XESC};

    // Slot being worked on by the sequencer
    typedef enum logic [2:0] {
        PH_WAIT,
        PH_CHMARK,
        PH_CHNUM,
        PH_CHESC,
        PH_BODY,
        PH_DESC
    } phase_e;

    // Source of the byte placed on the output this slot
    typedef enum logic [3:0] {
        SRC_IDLE,
        SRC_SOP,
        SRC_CHMARK,
        SRC_CHRAW,
        SRC_CHPFX,
        SRC_CHFOLD,
        SRC_EOP,
        SRC_DPFX,
        SRC_DRAW,
        SRC_DFOLD
    } src_e;

endpackage

// File: rtl/esc_framer_classify.sv
// Decides whether a byte collides with a reserved code and, if so,
// which escape prefix it takes and what its folded form is.
// Purely combinational; no assumption on the caller.
module esc_framer_classify
    import esc_framer_pkg::*;
(
    input  byte_t byte_i,
    output logic  esc_o,
    output byte_t pfx_o,
    output byte_t fold_o
);

    logic [N_PKT_CD-1:0] pkt_hit;
    logic [N_PHY_CD-1:0] phy_hit;

    // One comparator per packet-layer reserved code
    for (genvar gi = 0; gi < N_PKT_CD; gi++) begin : g_pkt
        assign pkt_hit[gi] = (byte_i == PKT_CODES[gi]);
    end

    // One comparator per physical-layer reserved code
    for (genvar gj = 0; gj < N_PHY_CD; gj++) begin : g_phy
        assign phy_hit[gj] = (byte_i == PHY_CODES[gj]);
    end

    // Pick the prefix by class and build the folded byte
    always_comb begin
        esc_o  = (|pkt_hit) || (|phy_hit);
        pfx_o  = (|phy_hit) ? MK_XESC : MK_PESC;
        fold_o = byte_i ^ FOLD_MASK;
    end

endmodule

// File: rtl/esc_framer_seq.sv
// Slot sequencer: walks header, body, escape and end-marker slots and
// advances only on a pulled slot. Assumes the source holds in_valid,
// in_data and in_last stable until in_ready.
module esc_framer_seq
    import esc_framer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    input  logic out_take,
    input  logic data_esc,
    input  logic chan_esc,
    output src_e src_o,
    output logic in_ready
);

    phase_e phase_q, phase_d;
    logic   eop_sent_q, eop_sent_d;

    // Next phase, output source and consume decision for this slot
    always_comb begin
        phase_d    = phase_q;
        eop_sent_d = eop_sent_q;
        src_o      = SRC_IDLE;
        in_ready   = 1'b0;
        unique case (phase_q)
            PH_WAIT: begin
                if (in_valid) begin
                    src_o = SRC_SOP;
                    if (out_take) begin
                        phase_d    = PH_CHMARK;
                        eop_sent_d = 1'b0;
                    end
                end
            end
            PH_CHMARK: begin
                src_o = SRC_CHMARK;
                if (out_take) phase_d = PH_CHNUM;
            end
            PH_CHNUM: begin
                if (chan_esc) begin
                    src_o = SRC_CHPFX;
                    if (out_take) phase_d = PH_CHESC;
                end else begin
                    src_o = SRC_CHRAW;
                    if (out_take) phase_d = PH_BODY;
                end
            end
            PH_CHESC: begin
                src_o = SRC_CHFOLD;
                if (out_take) phase_d = PH_BODY;
            end
            PH_BODY: begin
                if (!in_valid) begin
                    src_o = SRC_IDLE;
                end else if (in_last && !eop_sent_q) begin
                    src_o = SRC_EOP;
                    if (out_take) eop_sent_d = 1'b1;
                end else if (data_esc) begin
                    src_o = SRC_DPFX;
                    if (out_take) phase_d = PH_DESC;
                end else begin
                    src_o    = SRC_DRAW;
                    in_ready = out_take;
                    if (out_take && in_last) phase_d = PH_WAIT;
                end
            end
            PH_DESC: begin
                src_o    = SRC_DFOLD;
                in_ready = out_take;
                if (out_take) phase_d = in_last ? PH_WAIT : PH_BODY;
            end
            default: phase_d = PH_WAIT;
        endcase
    end

    // State update with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_WAIT;
            eop_sent_q <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            eop_sent_q <= eop_sent_d;
        end
    end

endmodule

// File: rtl/esc_framer_outsel.sv
// Output selector: maps the sequencer's source choice onto a byte.
// Combinational; assumes the classifier outputs match the held input.
module esc_framer_outsel
    import esc_framer_pkg::*;
(
    input  src_e  src_i,
    input  byte_t data_raw,
    input  byte_t data_pfx,
    input  byte_t data_fold,
    input  byte_t chan_raw,
    input  byte_t chan_pfx,
    input  byte_t chan_fold,
    output byte_t byte_o
);

    // One byte per source, idle by default
    always_comb begin
        unique case (src_i)
            SRC_SOP:    byte_o = MK_SOP;
            SRC_CHMARK: byte_o = MK_CHAN;
            SRC_CHRAW:  byte_o = chan_raw;
            SRC_CHPFX:  byte_o = chan_pfx;
            SRC_CHFOLD: byte_o = chan_fold;
            SRC_EOP:    byte_o = MK_EOP;
            SRC_DPFX:   byte_o = data_pfx;
            SRC_DRAW:   byte_o = data_raw;
            SRC_DFOLD:  byte_o = data_fold;
            default:    byte_o = MK_IDLE;
        endcase
    end

endmodule

// File: rtl/esc_framer.sv
// Top of the escaped packet framer. It presents one byte per slot to a
// pulling shifter and fills empty slots with idle. The channel number is
// a parameter (default 0) and is escaped like payload. Assumes a source
// that holds its byte until in_ready.
module esc_framer
    import esc_framer_pkg::*;
#(
    parameter logic [7:0] CHAN_ID = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       out_take,
    output logic [7:0] out_byte
);

    logic  d_esc, c_esc;
    byte_t d_pfx, d_fold, c_pfx, c_fold;
    src_e  src;

    esc_framer_classify u_cls_data (
        .byte_i (in_data),
        .esc_o  (d_esc),
        .pfx_o  (d_pfx),
        .fold_o (d_fold)
    );

    esc_framer_classify u_cls_chan (
        .byte_i (CHAN_ID),
        .esc_o  (c_esc),
        .pfx_o  (c_pfx),
        .fold_o (c_fold)
    );

    esc_framer_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_last  (in_last),
        .out_take (out_take),
        .data_esc (d_esc),
        .chan_esc (c_esc),
        .src_o    (src),
        .in_ready (in_ready)
    );

    esc_framer_outsel u_sel (
        .src_i     (src),
        .data_raw  (in_data),
        .data_pfx  (d_pfx),
        .data_fold (d_fold),
        .chan_raw  (CHAN_ID),
        .chan_pfx  (c_pfx),
        .chan_fold (c_fold),
        .byte_o    (out_byte)
    );

endmodule

// File: rtl/esc_framer_chk.sv
// Property checker for esc_framer, bound to every instance.
// Assumes the default channel number 0, which never needs escaping.
module esc_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_data,
    input logic       in_last,
    input logic       in_ready,
    input logic       out_take,
    input logic [7:0] out_byte
);

    function automatic logic pkt_cls(input logic [7:0] b);
        return (b == 8'h7A) || (b == 8'h7B) || (b == 8'h7C) || (b == 8'h7D);
    endfunction

    function automatic logic phy_cls(input logic [7:0] b);
        return (b == 8'h4A) || (b == 8'h4D);
    endfunction

    assert_ready_needs_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (out_take && in_valid));

    assert_consumed_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !(pkt_cls(out_byte) || phy_cls(out_byte)));

    assert_consumed_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> ((out_byte == in_data) || (out_byte == (in_data ^ 8'h20))));

    assert_pkt_prefix_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_take && out_byte == 8'h7D) |-> (!in_ready && pkt_cls(in_data)));

    assert_phy_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_take && out_byte == 8'h4D) |-> (!in_ready && phy_cls(in_data)));

    assert_eop_on_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_take && out_byte == 8'h7B) |-> (in_valid && in_last && !in_ready));

    assert_idle_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (out_byte == 8'h4A && !in_ready));

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(out_take) && $stable(in_valid) && $stable(in_data) && $stable(in_last))
            |-> $stable(out_byte));

endmodule

bind esc_framer esc_framer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .out_take (out_take),
    .out_byte (out_byte)
);

// File: tb/sim_esc_framer.sv
module sim_esc_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       out_take = 1'b0;
    logic [7:0] out_byte;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit checking = 1'b0;

    // entry: [11:9] kind, [8] consumes input, [7:0] byte
    logic [11:0] expq[$];

    always #2 clk = ~clk;

    esc_framer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .out_take(out_take), .out_byte(out_byte)
    );

    function automatic string kind_req(input logic [2:0] k);
        case (k)
            3'd0: return "R2";
            3'd1: return "R10";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Build the expected physical stream of one packet
    task automatic push_pkt(input logic [7:0] b [3], input int len);
        logic [2:0] hk;
        hk = (len == 1) ? 3'd5 : 3'd0;
        expq.push_back({hk, 1'b0, 8'h7A});
        expq.push_back({hk, 1'b0, 8'h7C});
        expq.push_back({hk, 1'b0, 8'h00});
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = b[i];
            if (i == len - 1) expq.push_back({(len == 1) ? 3'd5 : 3'd4, 1'b0, 8'h7B});
            if (v == 8'h7A || v == 8'h7B || v == 8'h7C || v == 8'h7D) begin
                expq.push_back({3'd2, 1'b0, 8'h7D});
                expq.push_back({3'd2, 1'b1, v ^ 8'h20});
            end else if (v == 8'h4A || v == 8'h4D) begin
                expq.push_back({3'd3, 1'b0, 8'h4D});
                expq.push_back({3'd3, 1'b1, v ^ 8'h20});
            end else begin
                expq.push_back({3'd1, 1'b1, v});
            end
        end
    endtask

    // Drive one packet with a valid/ready handshake and optional gaps
    task automatic send_pkt(input logic [7:0] b [3], input int len, input int gap);
        push_pkt(b, len);
        for (int i = 0; i < len; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_data  = b[i];
            in_last  = (i == len - 1);
            forever begin
                @(negedge clk);
                if (in_ready) break;
            end
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_last  = 1'b0;
            in_data  = 8'h55;
            for (int g = 0; g < gap; g++) @(posedge clk);
        end
    endtask

    // Shifter model: deterministic pull pattern with stalls
    initial begin
        int k = 0;
        forever begin
            @(posedge clk); #1;
            out_take = ((k % 7) != 3) && ((k % 11) != 5);
            k++;
        end
    end

    // Stream checker, sampled mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (checking) begin
                if (!in_valid) begin
                    check("R6", {in_ready, out_byte}, {1'b0, 8'h4A});
                end else if (expq.size() == 0) begin
                    check("R2", {1'b0, out_byte}, {1'b0, 8'hFF});
                end else begin
                    logic [11:0] e;
                    e = expq[0];
                    if (out_take) begin
                        check(kind_req(e[11:9]), {1'b0, out_byte}, {1'b0, e[7:0]});
                        check("R7", {8'h00, in_ready}, {8'h00, e[8]});
                        void'(expq.pop_front());
                    end else begin
                        check("R9", {in_ready, out_byte}, {1'b0, e[7:0]});
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] pk [3];
        logic [7:0] sp [6];
        sp = '{8'h7A, 8'h7B, 8'h7C, 8'h7D, 8'h4A, 8'h4D};
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {in_ready, out_byte}, {1'b0, 8'h4A});
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check("R1", {in_ready, out_byte}, {1'b0, 8'h4A});
        end
        checking = 1'b1;
        // R8: one-byte packets, all reserved codes plus a spread of others
        for (int s = 0; s < 6; s++) begin
            pk = '{sp[s], 8'h00, 8'h00};
            send_pkt(pk, 1, s % 2);
        end
        for (int v = 0; v < 256; v += 17) begin
            pk = '{v[7:0], 8'h00, 8'h00};
            send_pkt(pk, 1, 0);
        end
        // Every byte value in first, middle and last position
        for (int v = 0; v < 256; v++) begin
            pk = '{v[7:0], 8'd255 - v[7:0], v[7:0]};
            send_pkt(pk, 3, v % 3);
        end
        // Two-byte packets pairing reserved codes back to back
        for (int s = 0; s < 6; s++) begin
            pk = '{sp[s], sp[5 - s], 8'h00};
            send_pkt(pk, 2, 0);
        end
        repeat (40) @(posedge clk);
        check("R5", {1'b0, expq.size() == 0 ? 8'h00 : 8'h01}, 9'h000);
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule